// File: doc/BRIEF.md
# I2C Bit-Timing Parameter Calculator

This unit turns two numbers, the frequency in hertz of the clock that feeds an I2C master and the bus bitrate it should run at, into the settings that master needs. It first classes the bitrate into one of five speed classes. From that class it picks a glitch-filter depth, a pin drive style and whether acknowledge errors are ignored. It then looks for the smallest clock prescaler, from 0 to 7, that brings the SCL low count under 64 ticks. The SCL high and low counts come from a fixed 1:2 split of the cycle count, and the setup/hold and data-valid delays are derived from the high count.

A caller presents the two frequencies and pulses `start_i`. The unit then runs on its own for a few dozen cycles. When it finishes it raises `done_o` for exactly one cycle, and at that point every result output is valid. The result outputs keep their values until the next completion. If `err_o` is high alongside `done_o`, no prescaler was usable, and both the timing word and the prescaler read as zero.

Top module: `i2ct_calc`

## Requirements
- R1: `mode_o` holds the speed class of the bitrate: 0 below 400000 Hz, 1 below 1000000 Hz, 2 below 3400000 Hz, 3 below 5000000 Hz, and 4 at 5000000 Hz or more.
- R2: The filter depth `filt_o` is 0 for classes 3 and 4 and 2 for every other class. `filt_word_o` carries that depth in bits 19:16 and again in bits 27:24, and is zero in all other bits.
- R3: For prescaler p, the cycle count is c = floor(fclk / (2^p * rate)) - 3 - (filter >> 1). The smallest p in 0..7 whose low count is below 64 is reported in `prescale_o`.
- R4: The high count is ceil(c / 3) and the low count is c minus the high count.
- R5: `timing_o` is {data-valid, setup/hold, high, low}, one byte each from bit 31 down to bit 0. Setup/hold equals the high count and data-valid equals the high count shifted right by one.
- R6: `hs_set_o` is 1 exactly when the class is 3, which means the timing word is meant for the high-speed timing set.
- R7: In class 4, `pin_cfg_o` is 1 (two-pin output-only) and `ign_nack_o` is 1. In every other class, `pin_cfg_o` is 0 (two-pin open-drain) and `ign_nack_o` is 0.
- R8: If no prescaler up to 7 gives a low count below 64, the unit completes with `err_o` = 1.
- R9: A zero bitrate, or a cycle count that would be negative, completes with `err_o` = 1 and does not wrap. On any error, `timing_o` and `prescale_o` are 0.
- R10: Each accepted start produces exactly one single-cycle `done_o` pulse. A `start_i` that arrives while a calculation is running is ignored, and the results only change on a `done_o` cycle.
- R11: After reset, `done_o`, `err_o`, `timing_o` and `prescale_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calculation (sampled only when idle) |
| fclk_hz_i | input | 32 | Functional clock frequency in Hz |
| rate_hz_i | input | 32 | Target bus bitrate in Hz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No valid setting was found |
| mode_o | output | 3 | Speed class code |
| prescale_o | output | 3 | Chosen prescaler exponent |
| filt_o | output | 4 | Glitch-filter depth |
| filt_word_o | output | 32 | Filter depth placed for both SDA and SCL |
| pin_cfg_o | output | 2 | Pin drive style |
| ign_nack_o | output | 1 | Ignore acknowledge errors |
| hs_set_o | output | 1 | Timing word is for the high-speed set |
| timing_o | output | 32 | Packed timing word |

## Verification
The bitrate is stepped across every class edge: exactly 400 kHz, 1 MHz, 3.4 MHz and 5 MHz, plus a rate inside the standard class. These runs separate the five class encodings, the two filter depths and the pin and high-speed flags. Clock and rate pairs are chosen so that the cycle count lands on 95 and on 96, which tells an inclusive low-count bound apart from an exclusive one and shows the search stepping to the next prescaler. A cycle count of exactly 0 shows the search accepts without wrapping. A zero rate, a count that goes negative, and a pair with no usable prescaler each exercise one error path. A second start sent mid-run shows that the first result is kept and that only one completion is produced.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        SPD_STD   = 3'd0,
        SPD_FAST  = 3'd1,
        SPD_FPLUS = 3'd2,
        SPD_HS    = 3'd3,
        SPD_ULTRA = 3'd4
    } speed_e;

    typedef enum logic [1:0] {
        PIN_OPEN_DRAIN = 2'd0,
        PIN_OUT_ONLY   = 2'd1
    } pin_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_SEARCH
    } calc_st_e;

    localparam int unsigned FAST_MIN_HZ  = 400_000;
    localparam int unsigned FPLUS_MIN_HZ = 1_000_000;
    localparam int unsigned HS_MIN_HZ    = 3_400_000;
    localparam int unsigned ULTRA_MIN_HZ = 5_000_000;

    localparam int FILT_W      = 4;
    localparam int FILT_NORMAL = 2;
    localparam int FIXED_OVH   = 3;

    typedef struct packed {
        logic [7:0] datavd;
        logic [7:0] sethold;
        logic [7:0] hi;
        logic [7:0] lo;
    } timing_t;

    typedef struct packed {
        speed_e              mode;
        logic [FILT_W-1:0]   filt;
        pin_e                pin;
        logic                ign_nack;
        logic                hs_set;
    } cfg_t;

    function automatic speed_e speed_of(input logic [31:0] rate);
        if (rate < FAST_MIN_HZ)       return SPD_STD;
        else if (rate < FPLUS_MIN_HZ) return SPD_FAST;
        else if (rate < HS_MIN_HZ)    return SPD_FPLUS;
        else if (rate < ULTRA_MIN_HZ) return SPD_HS;
        else                          return SPD_ULTRA;
    endfunction

    function automatic logic [FILT_W-1:0] filt_of(input speed_e m);
        return (m == SPD_HS || m == SPD_ULTRA) ? '0 : FILT_W'(FILT_NORMAL);
    endfunction

endpackage

// File: rtl/i2ct_mode_sel.sv
module i2ct_mode_sel
    import i2ct_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] rate_i,
    output cfg_t              cfg_o
);

    speed_e spd;

    always_comb begin
        spd             = speed_of(32'(rate_i));
        cfg_o.mode      = spd;
        cfg_o.filt      = filt_of(spd);
        cfg_o.pin       = (spd == SPD_ULTRA) ? PIN_OUT_ONLY : PIN_OPEN_DRAIN;
        cfg_o.ign_nack  = (spd == SPD_ULTRA);
        cfg_o.hs_set    = (spd == SPD_HS);
    end

endmodule

// File: rtl/i2ct_divider.sv
module i2ct_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);

    localparam int CNT_W = $clog2(NUM_W);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] num_sh;
    logic [NUM_W-1:0] quo;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    assign trial = {rem, num_sh[NUM_W-1]};
    assign diff  = trial - {1'b0, den_q};
    assign fits  = trial >= {1'b0, den_q};
    assign quo_o = quo;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            rem    <= '0;
            den_q  <= '0;
            num_sh <= '0;
            quo    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                busy   <= 1'b1;
                cnt    <= '0;
                rem    <= '0;
                den_q  <= den_i;
                num_sh <= num_i;
                quo    <= '0;
            end else if (busy) begin
                rem    <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo    <= {quo[NUM_W-2:0], fits};
                num_sh <= num_sh << 1;
                cnt    <= cnt + 1'b1;
                if (cnt == CNT_W'(NUM_W - 1)) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2ct_timing_pack.sv
module i2ct_timing_pack
    import i2ct_pkg::*;
#(
    parameter int CYC_W = 7
) (
    input  logic [CYC_W-1:0] cyc_i,
    output timing_t          tim_o
);

    logic [CYC_W:0] hi;
    logic [CYC_W:0] lo;

    always_comb begin
        hi            = ({1'b0, cyc_i} + (CYC_W+1)'(2)) / (CYC_W+1)'(3);
        lo            = {1'b0, cyc_i} - hi;
        tim_o.hi      = 8'(hi);
        tim_o.lo      = 8'(lo);
        tim_o.sethold = 8'(hi);
        tim_o.datavd  = 8'(hi >> 1);
    end

endmodule

// File: rtl/i2ct_calc.sv
module i2ct_calc
    import i2ct_pkg::*;
#(
    parameter int FCLK_W   = 32,
    parameter int RATE_W   = 32,
    parameter int PRE_MAX  = 7,
    parameter int LO_LIMIT = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [FCLK_W-1:0]    fclk_hz_i,
    input  logic [RATE_W-1:0]    rate_hz_i,
    output logic                 done_o,
    output logic                 err_o,
    output logic [2:0]           mode_o,
    output logic [2:0]           prescale_o,
    output logic [3:0]           filt_o,
    output logic [31:0]          filt_word_o,
    output logic [1:0]           pin_cfg_o,
    output logic                 ign_nack_o,
    output logic                 hs_set_o,
    output logic [31:0]          timing_o
);

    localparam int PRE_W     = $clog2(PRE_MAX + 1);
    localparam int CYC_LIMIT = (3 * LO_LIMIT + 1) / 2;
    localparam int CYC_W     = $clog2(CYC_LIMIT);

    calc_st_e          st;
    logic [PRE_W-1:0]  pre;
    logic [FCLK_W-1:0] fclk_q;
    logic [RATE_W-1:0] rate_q;
    logic [FCLK_W-1:0] q0_q;
    cfg_t              cfg;
    timing_t           tim;
    logic              div_start;
    logic              div_done;
    logic [FCLK_W-1:0] div_quo;
    logic [FCLK_W-1:0] q_pre;
    logic [FCLK_W-1:0] ovh;
    logic [FCLK_W-1:0] cyc_full;
    logic              cyc_neg;
    logic              cyc_fits;
    logic              fin;
    logic              fin_err;

    i2ct_mode_sel #(.RATE_W(RATE_W)) u_mode (
        .rate_i (rate_q),
        .cfg_o  (cfg)
    );

    i2ct_divider #(.NUM_W(FCLK_W), .DEN_W(RATE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .num_i   (fclk_q),
        .den_i   (rate_q),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    i2ct_timing_pack #(.CYC_W(CYC_W)) u_pack (
        .cyc_i (cyc_full[CYC_W-1:0]),
        .tim_o (tim)
    );

    assign div_start = (st == ST_LAUNCH) && (rate_q != '0);
    assign q_pre     = q0_q >> pre;
    assign ovh       = FCLK_W'(FIXED_OVH) + FCLK_W'(cfg.filt >> 1);
    assign cyc_neg   = q_pre < ovh;
    assign cyc_full  = q_pre - ovh;
    assign cyc_fits  = cyc_full < FCLK_W'(CYC_LIMIT);

    always_comb begin
        fin     = 1'b0;
        fin_err = 1'b0;
        case (st)
            ST_LAUNCH: begin
                if (rate_q == '0) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end
            end
            ST_SEARCH: begin
                if (cyc_neg) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end else if (cyc_fits) begin
                    fin     = 1'b1;
                end else if (pre == PRE_W'(PRE_MAX)) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pre        <= '0;
            fclk_q     <= '0;
            rate_q     <= '0;
            q0_q       <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            mode_o     <= '0;
            prescale_o <= '0;
            filt_o     <= '0;
            pin_cfg_o  <= '0;
            ign_nack_o <= 1'b0;
            hs_set_o   <= 1'b0;
            timing_o   <= '0;
        end else begin
            done_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        fclk_q <= fclk_hz_i;
                        rate_q <= rate_hz_i;
                        pre    <= '0;
                        st     <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: st <= ST_WAIT;
                ST_WAIT: begin
                    if (div_done) begin
                        q0_q <= div_quo;
                        st   <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (!fin) pre <= pre + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
            if (fin) begin
                st         <= ST_IDLE;
                done_o     <= 1'b1;
                err_o      <= fin_err;
                mode_o     <= cfg.mode;
                filt_o     <= cfg.filt;
                pin_cfg_o  <= cfg.pin;
                ign_nack_o <= cfg.ign_nack;
                hs_set_o   <= cfg.hs_set;
                prescale_o <= fin_err ? 3'd0 : 3'(pre);
                timing_o   <= fin_err ? 32'd0 : tim;
            end
        end
    end

    assign filt_word_o = {4'd0, filt_o, 4'd0, filt_o, 16'd0};

endmodule

// File: rtl/i2ct_calc_chk.sv
module i2ct_calc_chk #(
    parameter int LO_LIMIT = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        done_o,
    input logic        err_o,
    input logic [2:0]  mode_o,
    input logic [2:0]  prescale_o,
    input logic [3:0]  filt_o,
    input logic [1:0]  pin_cfg_o,
    input logic        ign_nack_o,
    input logic        hs_set_o,
    input logic [31:0] timing_o
);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(timing_o) && $stable(prescale_o)));

    p_lo_fits_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (32'(timing_o[7:0]) < LO_LIMIT));

    p_ratio_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (({1'b0, timing_o[7:0]} <= {timing_o[15:8], 1'b0})
                               && ({1'b0, timing_o[15:8]} <= {1'b0, timing_o[7:0]} + 9'd1)));

    p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (timing_o == 32'd0 && prescale_o == 3'd0));

    p_pin_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((ign_nack_o == (pin_cfg_o == 2'd1)) && (ign_nack_o == (mode_o == 3'd4))));

    p_hs_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (hs_set_o == (mode_o == 3'd3)));

    p_filt_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((filt_o == 4'd0) == (mode_o >= 3'd3)));

endmodule

bind i2ct_calc i2ct_calc_chk #(.LO_LIMIT(LO_LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done_o     (done_o),
    .err_o      (err_o),
    .mode_o     (mode_o),
    .prescale_o (prescale_o),
    .filt_o     (filt_o),
    .pin_cfg_o  (pin_cfg_o),
    .ign_nack_o (ign_nack_o),
    .hs_set_o   (hs_set_o),
    .timing_o   (timing_o)
);

// File: tb/i2ct_calc_bench.sv
module i2ct_calc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] fclk_hz_i = '0;
    logic [31:0] rate_hz_i = '0;
    logic        done_o;
    logic        err_o;
    logic [2:0]  mode_o;
    logic [2:0]  prescale_o;
    logic [3:0]  filt_o;
    logic [31:0] filt_word_o;
    logic [1:0]  pin_cfg_o;
    logic        ign_nack_o;
    logic        hs_set_o;
    logic [31:0] timing_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit got_done;

    always #2.5 clk = ~clk;

    i2ct_calc u_i2ct_calc (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .fclk_hz_i   (fclk_hz_i),
        .rate_hz_i   (rate_hz_i),
        .done_o      (done_o),
        .err_o       (err_o),
        .mode_o      (mode_o),
        .prescale_o  (prescale_o),
        .filt_o      (filt_o),
        .filt_word_o (filt_word_o),
        .pin_cfg_o   (pin_cfg_o),
        .ign_nack_o  (ign_nack_o),
        .hs_set_o    (hs_set_o),
        .timing_o    (timing_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference computed straight from the requirement formulas
    task automatic model(input longint fclk, input longint rate,
                         output int mode, output int filt, output int pre,
                         output bit err, output longint word);
        longint c, hi, lo;
        mode = (rate < 400000) ? 0 : (rate < 1000000) ? 1 : (rate < 3400000) ? 2 :
               (rate < 5000000) ? 3 : 4;
        filt = (mode >= 3) ? 0 : 2;
        err  = 1'b1;
        pre  = 0;
        word = 0;
        if (rate != 0) begin
            for (int p = 0; p <= 7; p++) begin
                c = fclk / (rate << p) - 3 - (filt >> 1);
                if (c < 0) break;
                hi = (c + 2) / 3;
                lo = c - hi;
                if (lo < 64) begin
                    err  = 1'b0;
                    pre  = p;
                    word = ((hi >> 1) << 24) | (hi << 16) | (hi << 8) | lo;
                    break;
                end
            end
        end
    endtask

    task automatic kick(input longint fclk, input longint rate);
        @(negedge clk);
        fclk_hz_i = 32'(fclk);
        rate_hz_i = 32'(rate);
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    task automatic await_done();
        got_done = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done_o) begin
                got_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_and_check(input longint fclk, input longint rate, input string tag);
        int mode, filt, pre;
        bit err;
        longint word;
        model(fclk, rate, mode, filt, pre, err, word);
        kick(fclk, rate);
        await_done();
        check(got_done, {tag, " R10 done seen"}, got_done, 1);
        check(err_o == err, {tag, " R8/R9 err"}, err_o, err);
        check(mode_o == 3'(mode), {tag, " R1 mode"}, mode_o, mode);
        check(filt_o == 4'(filt), {tag, " R2 filt"}, filt_o, filt);
        check(filt_word_o == ((32'(filt) << 24) | (32'(filt) << 16)), {tag, " R2 filt word"},
              filt_word_o, (longint'(filt) << 24) | (longint'(filt) << 16));
        check(prescale_o == 3'(pre), {tag, " R3 prescale"}, prescale_o, pre);
        check(timing_o == 32'(word), {tag, " R4 R5 timing"}, timing_o, word);
        check(hs_set_o == (mode == 3), {tag, " R6 hs set"}, hs_set_o, mode == 3);
        check(pin_cfg_o == ((mode == 4) ? 2'd1 : 2'd0), {tag, " R7 pin"}, pin_cfg_o, mode == 4);
        check(ign_nack_o == (mode == 4), {tag, " R7 ignack"}, ign_nack_o, mode == 4);
        @(negedge clk);
        check(!done_o, {tag, " R10 single pulse"}, done_o, 0);
    endtask

    task automatic t_reset();
        check(!done_o && !err_o, "R11 reset flags", {done_o, err_o}, 0);
        check(timing_o == 0 && prescale_o == 0, "R11 reset outputs", timing_o, 0);
    endtask

    task automatic t_classes();
        run_and_check(24_000_000, 100_000,   "std");
        run_and_check(24_000_000, 400_000,   "fast edge");
        run_and_check(48_000_000, 1_000_000, "fplus edge");
        run_and_check(60_000_000, 3_400_000, "hs edge");
        run_and_check(60_000_000, 5_000_000, "ultra edge");
        run_and_check(60_000_000, 4_999_999, "hs top");
    endtask

    task automatic t_bounds();
        // R3: count 95 fits at p0, count 96 must step to p1
        run_and_check(9_900_000, 100_000, "cyc95");
        check(prescale_o == 3'd0 && timing_o[7:0] == 8'd63, "R3 cyc95 p0", timing_o, 32'h10_20_20_3f);
        run_and_check(10_000_000, 100_000, "cyc96");
        check(prescale_o == 3'd1, "R3 cyc96 next p", prescale_o, 1);
        // R4: zero cycle count accepted without wrap
        run_and_check(4_000_000, 1_000_000, "cyc0");
        check(!err_o && timing_o == 0, "R4 cyc0", timing_o, 0);
    endtask

    task automatic t_errors();
        run_and_check(24_000_000, 0, "zero rate");
        check(err_o, "R9 zero rate err", err_o, 1);
        run_and_check(1_000_000, 400_000, "negative");
        check(err_o, "R9 negative err", err_o, 1);
        run_and_check(100_000_000, 1000, "nofit");
        check(err_o, "R8 no prescaler err", err_o, 1);
    endtask

    task automatic t_busy_ignore();
        int mode, filt, pre;
        bit err;
        longint word;
        int extra;
        model(24_000_000, 100_000, mode, filt, pre, err, word);
        kick(24_000_000, 100_000);
        repeat (4) @(negedge clk);
        fclk_hz_i = 32'd60_000_000;
        rate_hz_i = 32'd5_000_000;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        await_done();
        check(got_done && timing_o == 32'(word) && mode_o == 3'(mode),
              "R10 busy start ignored", timing_o, word);
        extra = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0, "R10 no second done", extra, 0);
        check(timing_o == 32'(word), "R10 result held", timing_o, word);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_classes();
        t_bounds();
        t_errors();
        t_busy_ignore();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule